// File: doc/BRIEF.md
# Byte-Write Synchronous SRAM with Sleep

This block is a single-port synchronous static RAM. Each word is split into 9-bit byte lanes: 8 data bits and 1 parity bit per lane. All control inputs are sampled on the rising clock edge. The shared data bus is modelled as three signals: an input vector, an output vector and one drive-enable. A write carries its data in the same cycle as the command. Only the lanes whose byte-select is low are stored.

A read returns the word one cycle after the command. The drivers are turned on only when all of these hold:
- that cycle follows a read command,
- output enable is low,
- the array is awake,
- the current cycle is not a write.

A load/advance control starts a new access (low) or continues the previous one at the next address (high). The next address is formed by a separate burst-address unit that steps the two low address bits linearly, wrapping inside a group of four words.

A sleep request may arrive asynchronously. It is first passed through a two-flop synchronizer. Entering and leaving sleep then each take two further cycles. From the moment the synchronized request is seen until sleep has been fully left, the array ignores commands and drops any access in progress. The stored words are kept throughout.

Top module: `ssram_bw`

## Requirements
- R1: In a write, byte lane i (bits 9i+8 down to 9i) is stored only when bw_n[i] is 0. Lanes with bw_n[i] at 1 keep their previous contents.
- R2: A read command is ce_n=0, we_n=1, adv_ld=0. In the following cycle d_out holds the addressed word, and d_oe is 1 when oe_n is 0.
- R3: While oe_n is 1, d_oe is 0.
- R4: d_oe is 0 in every cycle that performs a write, including a write that directly follows a read, whatever oe_n is.
- R5: A load cycle with ce_n=1 deselects the array. Nothing is written, no read data is driven, and a later advance cycle performs no access.
- R6: With adv_ld=1, the previous operation continues at the previous address with its low two bits incremented by one modulo 4, so a burst from address 3 of a group continues at 0, 1, 2 of the same group. In these cycles ce_n and we_n are ignored and bw_n is sampled again.
- R7: asleep rises on the fourth rising edge after sleep_req is first sampled high. It falls on the fourth rising edge after sleep_req is first sampled low.
- R8: While sleep is being entered, is held or is being left, commands are ignored, d_oe stays 0 and any access in progress is discarded. Stored contents survive sleep unchanged.
- R9: After reset, d_oe and asleep are 0 and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, sampled on load cycles |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new access, 1 continues the current burst |
| bw_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | 9*LANES | Write data bus |
| d_out | output | 9*LANES | Read data bus |
| d_oe | output | 1 | Drive enable for d_out |
| sleep_req | input | 1 | Asynchronous sleep request |
| asleep | output | 1 | High while the array is asleep |

## Verification
The operation state is held one cycle ahead of the ports, so a corrupted state shows on the very next cycle. It appears either as d_oe driving on a cycle that should be quiet, or as a burst step reading or writing the wrong word of its four-word group. That wrong word then appears in d_out one cycle later. A wrong sleep counter moves the edge of asleep away from the fourth clock, or lets a write slip through while dozing. The second case is only seen when the word is read back after waking, so the bench rereads every word it has touched.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // next position inside a four-word burst group, linear order
    function automatic logic [1:0] burst_step(input logic [1:0] lo);
        return lo + 2'd1;
    endfunction

endpackage

// File: rtl/ssram_sleep.sv
module ssram_sleep #(
    parameter int SYNC_STAGES = 2,
    parameter int TRANS_CYC   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic sync_lvl,
    output logic asleep,
    output logic doze
);
    localparam int CW = $clog2(TRANS_CYC + 1);

    logic [SYNC_STAGES-1:0] sh_q;
    logic [CW-1:0]          cnt_q;
    logic                   asleep_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], sleep_req};
    end

    assign sync_lvl = sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            asleep_q <= 1'b0;
        end else if (sync_lvl != asleep_q) begin
            if (cnt_q == CW'(TRANS_CYC - 1)) begin
                asleep_q <= sync_lvl;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign asleep = asleep_q;
    assign doze   = sync_lvl | asleep_q;

endmodule

// File: rtl/ssram_burst.sv
module ssram_burst
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_eff
);
    logic [ADDR_W-1:0] cur_q;

    always_comb begin
        if (load) addr_eff = addr_in;
        else      addr_eff = {cur_q[ADDR_W-1:2], burst_step(cur_q[1:0])};
    end

    always_ff @(posedge clk) begin
        if (rst)               cur_q <= '0;
        else if (load || step) cur_q <= addr_eff;
    end

endmodule

// File: rtl/ssram_lane.sv
module ssram_lane
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/ssram_bw.sv
module ssram_bw
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce_n,
    input  logic                     we_n,
    input  logic                     adv_ld,
    input  logic [LANES-1:0]         bw_n,
    input  logic                     oe_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  d_in,
    output logic [LANES*LANE_W-1:0]  d_out,
    output logic                     d_oe,
    input  logic                     sleep_req,
    output logic                     asleep
);
    localparam int WORD_W = LANES * LANE_W;

    logic              sync_lvl;
    logic              doze;
    op_e               op_q;
    op_e               cur_op;
    logic              rd_v_q;
    logic              wr_now;
    logic              rd_now;
    logic [ADDR_W-1:0] addr_eff;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0][LANE_W-1:0] lane_rd;

    ssram_sleep #(.SYNC_STAGES(2), .TRANS_CYC(2)) u_sleep (
        .clk      (clk),
        .rst      (rst),
        .sleep_req(sleep_req),
        .sync_lvl (sync_lvl),
        .asleep   (asleep),
        .doze     (doze)
    );

    // operation for this cycle: load decodes the enables, advance repeats
    always_comb begin
        cur_op = OP_IDLE;
        if (!doze) begin
            if (!adv_ld) begin
                if (!ce_n) cur_op = we_n ? OP_RD : OP_WR;
            end else begin
                cur_op = op_q;
            end
        end
    end

    assign wr_now = (cur_op == OP_WR);
    assign rd_now = (cur_op == OP_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            rd_v_q <= 1'b0;
        end else begin
            op_q   <= cur_op;
            rd_v_q <= rd_now;
        end
    end

    ssram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .load    (!adv_ld),
        .step    (cur_op != OP_IDLE),
        .addr_in (addr),
        .addr_eff(addr_eff)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = wr_now & ~bw_n[g];

        ssram_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk  (clk),
            .we   (lane_we[g]),
            .re   (rd_now),
            .addr (addr_eff),
            .wdata(d_in[g*LANE_W +: LANE_W]),
            .rdata(lane_rd[g])
        );
    end

    assign d_out = WORD_W'(lane_rd);
    assign d_oe  = rd_v_q & ~oe_n & ~wr_now & ~doze;

endmodule

// File: rtl/ssram_bw_chk.sv
module ssram_bw_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             d_oe,
    input logic             oe_n,
    input logic             asleep,
    input logic             sync_lvl,
    input logic [LANES-1:0] lane_we
);

    // R3
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !d_oe);

    // R4
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (|lane_we) |-> !d_oe);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (!d_oe && !(|lane_we)));

    // R7
    sleep_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> $past(sync_lvl));

    // R7
    sleep_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> !$past(sync_lvl));

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!asleep && !d_oe));

endmodule

bind ssram_bw ssram_bw_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .d_oe    (d_oe),
    .oe_n    (oe_n),
    .asleep  (asleep),
    .sync_lvl(sync_lvl),
    .lane_we (lane_we)
);

// File: tb/tb_ssram_bw.sv
module tb_ssram_bw;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int LN = 4;
    localparam int DW = 36;

    localparam logic [DW-1:0] A0  = {9'h111, 9'h0AA, 9'h155, 9'h033};
    localparam logic [DW-1:0] B0  = {9'h0F0, 9'h00F, 9'h1C3, 9'h03C};
    localparam logic [DW-1:0] FF  = {4{9'h1FF}};
    localparam logic [DW-1:0] MIX = {9'h111, 9'h1FF, 9'h155, 9'h1FF};
    localparam logic [DW-1:0] C0  = {4{9'h055}};
    localparam logic [DW-1:0] Z0  = {4{9'h0C3}};
    localparam logic [DW-1:0] W0  = {4{9'h101}};
    localparam logic [DW-1:0] W1  = {4{9'h012}};
    localparam logic [DW-1:0] W2  = {4{9'h1E1}};
    localparam logic [DW-1:0] W3  = {4{9'h0B4}};
    localparam logic [DW-1:0] ZW2 = {9'h0C3, 9'h0C3, 9'h0C3, 9'h1E1};

    typedef struct packed {
        logic          ce_n;
        logic          we_n;
        logic          adv;
        logic          oe_n;
        logic [LN-1:0] bw_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic          c_oe;
        logic          e_oe;
        logic          c_d;
        logic [DW-1:0] e_d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 27;
    // fields: ce_n we_n adv oe_n bw_n addr din | chk_oe exp_oe chk_d exp_d req
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,4'h0,10'h010,A0, 1'b1,1'b0,1'b0,'0, 4'd4}, // R4 write, drivers off
        '{1'b0,1'b0,1'b0,1'b0,4'h0,10'h020,B0, 1'b0,1'b0,1'b0,'0, 4'd1},
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h010,'0, 1'b1,1'b0,1'b0,'0, 4'd2}, // R2 read issued
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b1,1'b1,1'b1,A0, 4'd2}, // R2 data next cycle
        '{1'b0,1'b0,1'b0,1'b0,4'hA,10'h010,FF, 1'b0,1'b0,1'b0,'0, 4'd1}, // R1 lanes 0,2
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h010,'0, 1'b0,1'b0,1'b0,'0, 4'd1},
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b1,1'b1,1'b1,MIX,4'd1}, // R1 merged word
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h020,'0, 1'b0,1'b0,1'b0,'0, 4'd3},
        '{1'b1,1'b1,1'b0,1'b1,4'hF,10'h000,'0, 1'b1,1'b0,1'b0,'0, 4'd3}, // R3 oe_n high
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h020,'0, 1'b0,1'b0,1'b0,'0, 4'd4},
        '{1'b0,1'b0,1'b0,1'b0,4'h0,10'h030,C0, 1'b1,1'b0,1'b0,'0, 4'd4}, // R4 write after read
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b1,1'b0,1'b0,'0, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0,4'h0,10'h010,'0, 1'b1,1'b0,1'b0,'0, 4'd5}, // R5 deselected write
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h010,'0, 1'b0,1'b0,1'b0,'0, 4'd5},
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b1,1'b1,1'b1,MIX,4'd5}, // R5 word untouched
        '{1'b0,1'b0,1'b0,1'b0,4'h0,10'h040,Z0, 1'b0,1'b0,1'b0,'0, 4'd6},
        '{1'b0,1'b0,1'b0,1'b0,4'h0,10'h042,W0, 1'b0,1'b0,1'b0,'0, 4'd6}, // R6 burst write load
        '{1'b1,1'b1,1'b1,1'b0,4'h0,10'h3FF,W1, 1'b1,1'b0,1'b0,'0, 4'd6}, // R6 -> 0x043
        '{1'b1,1'b1,1'b1,1'b0,4'hE,10'h3FF,W2, 1'b0,1'b0,1'b0,'0, 4'd6}, // R6 -> 0x040 lane0
        '{1'b1,1'b1,1'b1,1'b0,4'h0,10'h3FF,W3, 1'b0,1'b0,1'b0,'0, 4'd6}, // R6 -> 0x041
        '{1'b0,1'b1,1'b0,1'b0,4'hF,10'h043,'0, 1'b0,1'b0,1'b0,'0, 4'd6}, // R6 burst read load
        '{1'b1,1'b0,1'b1,1'b0,4'hF,10'h000,'0, 1'b1,1'b1,1'b1,W1, 4'd6},
        '{1'b1,1'b0,1'b1,1'b0,4'hF,10'h000,'0, 1'b0,1'b0,1'b1,ZW2,4'd6},
        '{1'b1,1'b0,1'b1,1'b0,4'hF,10'h000,'0, 1'b0,1'b0,1'b1,W3, 4'd6},
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b0,1'b0,1'b1,W0, 4'd6},
        '{1'b0,1'b0,1'b1,1'b0,4'h0,10'h010,'0, 1'b1,1'b0,1'b0,'0, 4'd5}, // R5 advance after idle
        '{1'b1,1'b1,1'b0,1'b0,4'hF,10'h000,'0, 1'b1,1'b0,1'b0,'0, 4'd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic [LN-1:0] bw_n = '1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] d_out;
    logic          d_oe;
    logic          sleep_req = 1'b0;
    logic          asleep;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssram_bw #(.ADDR_W(AW), .LANES(LN)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .adv_ld(adv_ld),
        .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .d_in(d_in), .d_out(d_out),
        .d_oe(d_oe), .sleep_req(sleep_req), .asleep(asleep)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        ce_n = 1'b1; we_n = 1'b1; adv_ld = 1'b0; bw_n = '1; oe_n = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished run");
            summary();
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 d_oe", DW'(d_oe), '0);
        check("R9 asleep", DW'(asleep), '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ce_n = VEC[i].ce_n; we_n = VEC[i].we_n; adv_ld = VEC[i].adv;
            oe_n = VEC[i].oe_n; bw_n = VEC[i].bw_n; addr = VEC[i].addr;
            d_in = VEC[i].din;
            #1;
            if (VEC[i].c_oe)
                check($sformatf("R%0d d_oe vec %0d", VEC[i].req, i), DW'(d_oe), DW'(VEC[i].e_oe));
            if (VEC[i].c_d)
                check($sformatf("R%0d d_out vec %0d", VEC[i].req, i), d_out, VEC[i].e_d);
        end

        // R7 R8: enter sleep with a burst read in progress
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; adv_ld = 1'b0; addr = 10'h020;
        @(negedge clk);
        ce_n = 1'b1; adv_ld = 1'b1; sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R7 asleep after 3 edges", DW'(asleep), '0);
        @(negedge clk);
        #1;
        check("R7 asleep after 4 edges", DW'(asleep), DW'(1));
        check("R8 d_oe while asleep", DW'(d_oe), '0);
        // R8 write attempt while asleep must be ignored
        adv_ld = 1'b0; ce_n = 1'b0; we_n = 1'b0; bw_n = '0; addr = 10'h010; d_in = '0;
        @(negedge clk);
        we_n = 1'b1; bw_n = '1;
        @(negedge clk);
        #1;
        check("R8 read while asleep", DW'(d_oe), '0);
        ce_n = 1'b1; we_n = 1'b1; adv_ld = 1'b1; sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 still asleep after 3 edges", DW'(asleep), DW'(1));
        @(negedge clk);
        #1;
        check("R7 awake after 4 edges", DW'(asleep), '0);
        repeat (2) @(negedge clk);
        #1;
        check("R8 pending burst discarded", DW'(d_oe), '0);
        // R8 contents preserved
        ce_n = 1'b0; we_n = 1'b1; adv_ld = 1'b0; addr = 10'h010;
        @(negedge clk);
        go_idle();
        #1;
        check("R8 d_oe after wake", DW'(d_oe), DW'(1));
        check("R8 contents kept", d_out, MIX);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule